// File: doc/BRIEF.md
# Flash Mass Erase Sequencer

This block supervises the high-voltage whole-array erase of an embedded flash. It watches bus writes to its control register and to the flash array window. It drives the high-voltage enable to the array and checks each step of the erase handshake.

The handshake has five steps, and they must come in this order:

1. Raise the erase request.
2. Write any value to the array window while the page select maps that window onto flash.
3. Raise the high-voltage request.
4. Drop the erase request.
5. Drop the high-voltage request.

Between steps 2–3, 3–4 and 4–5 a minimum wait applies. Each wait is a cycle count held in its own parameter. One shared down-counter measures all of the waits.

After the last step, a recovery interval runs before the array may be read again. If a step comes out of order or too early, the block latches a sticky error, forces high voltage off and returns to idle. Writes issued by code fetched from flash itself are rejected. Unrelated bus traffic between the steps is allowed.

Top module: `erase_sequencer`

## Requirements
- R1: After reset, hv_en = 0, erase_active = 0, seq_err = 0 and read_ready = 1.
- R2: The control register sits at CTRL_ADDR (default 0x10). Its fields are: bit 0 = erase request, bit 1 = high-voltage request, bit 7 = error clear. A write of 0x01 from idle, with no error latched, raises erase_active on the next cycle and lowers read_ready.
- R3: A write to addresses WIN_LO..WIN_HI (0xC0..0xFF) while win_on_flash = 1 arms the setup wait. A write below the window, or one made with win_on_flash = 0, does not arm it.
- R4: The high-voltage request (control write 0x03) is accepted only if at least T_SETUP cycles have passed since the window write. When accepted, hv_en rises on the next cycle.
- R5: Dropping the erase request (control write 0x02) is accepted only if at least T_ERASE cycles have passed since hv_en rose. When accepted, erase_active falls and hv_en stays high.
- R6: Dropping the high-voltage request (control write 0x00) is accepted only if at least T_HOLD cycles have passed since the erase request was dropped. When accepted, hv_en falls.
- R7: read_ready rises exactly T_RCV cycles after the accepted high-voltage drop.
- R8: Any of the following sets seq_err and returns the block to idle, with hv_en = 0 and erase_active = 0:
  - a step taken before its wait has expired;
  - a control value that is not the next step;
  - an array-window write during setup, erase or hold.
- R9: Any write with wr_from_flash = 1 has no effect.
- R10: seq_err stays set until reset or until a control write with bit 7 = 1. That clearing write changes nothing else. While seq_err is set, a request to start an erase is ignored.
- R11: Writes to other addresses, and control writes that repeat the current request bits, do not disturb the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| wr_from_flash | input | 1 | Current write issued by code fetched from flash |
| win_on_flash | input | 1 | Page select currently maps the array window onto flash |
| hv_en | output | 1 | High-voltage enable to the array |
| erase_active | output | 1 | Erase request currently applied |
| seq_err | output | 1 | Sticky sequence error |
| read_ready | output | 1 | Array readable (idle, recovery finished) |

## Verification
The bench builds the sequencer with T_SETUP = 3, T_ERASE = 5, T_HOLD = 2 and T_RCV = 4. With waits this short, it can sweep every timed step across every gap from one cycle up to one cycle past its minimum. The accept/reject boundary of each wait is therefore hit exactly, and recovery is checked on both sides of its edge.

The short waits also leave room inside the gaps for repeated control values and writes to other addresses. Finally, the bench runs the rejection paths: out-of-order values, an unmapped page, an address outside the window, flash-fetched writes, and clearing the error.

// File: rtl/erase_seq_pkg.sv
// Shared types for the flash erase sequencer.
// Assumes: the state encoding is internal and decoded only by erase_sequencer.
package erase_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARMED,
        S_SETUP,
        S_ERASE,
        S_HOLD,
        S_RECOVER
    } seq_state_t;
endpackage

// File: rtl/erase_seq_decode.sv
// Bus write decoder: classifies one write as a control-step write, an error-clear
// write or an array-window write. Writes from flash-fetched code are dropped here.
// Assumes: CTRL_ADDR lies outside WIN_LO..WIN_HI.
module erase_seq_decode #(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [AW-1:0] CTRL_ADDR = 8'h10,
    parameter logic [AW-1:0] WIN_LO    = 8'hC0,
    parameter logic [AW-1:0] WIN_HI    = 8'hFF,
    parameter int          ERASE_BIT = 0,
    parameter int          HV_BIT    = 1,
    parameter int          CLR_BIT   = 7
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_from_flash,
    input  logic          win_on_flash,
    output logic          ctrl_wr,
    output logic          req_erase,
    output logic          req_hv,
    output logic          clr_err,
    output logic          win_wr
);
    logic accepted;
    logic hit_ctrl;
    logic hit_win;

    // Classify the current write; only RAM or debug-port writes are accepted.
    always_comb begin
        accepted  = wr_en && !wr_from_flash;
        hit_ctrl  = (wr_addr == CTRL_ADDR);
        hit_win   = (wr_addr >= WIN_LO) && (wr_addr <= WIN_HI);
        clr_err   = accepted && hit_ctrl && wr_data[CLR_BIT];
        ctrl_wr   = accepted && hit_ctrl && !wr_data[CLR_BIT];
        req_erase = wr_data[ERASE_BIT];
        req_hv    = wr_data[HV_BIT];
        win_wr    = accepted && hit_win && win_on_flash;
    end
endmodule

// File: rtl/erase_seq_timer.sv
// Shared down-counter for all step waits: loaded with (wait - 1) when a step is
// taken, then counts to zero and holds. zero means the wait has expired.
// Assumes: load_val fits in CW bits.
module erase_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    // Load on a step, otherwise count down and saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // The wait measured after each step starts from the loaded value (R4, R5, R6, R7).
    assert_timer_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    // Between steps the counter steps down by exactly one per cycle (R4).
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/erase_sequencer.sv
// Flash erase sequencer: enforces erase-request, window write, high-voltage on,
// erase-request off, high-voltage off, with a minimum wait after each timed step,
// then a recovery interval before reads. Misorder or early steps abort with a
// sticky error and high voltage forced off.
// Assumes: all wait parameters are at least 1; synchronous active-low reset.
module erase_sequencer
    import erase_seq_pkg::*;
#(
    parameter int            AW        = 8,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] CTRL_ADDR = 8'h10,
    parameter logic [AW-1:0] WIN_LO    = 8'hC0,
    parameter logic [AW-1:0] WIN_HI    = 8'hFF,
    parameter int            T_SETUP   = 10,
    parameter int            T_ERASE   = 200,
    parameter int            T_HOLD    = 5,
    parameter int            T_RCV     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_from_flash,
    input  logic          win_on_flash,
    output logic          hv_en,
    output logic          erase_active,
    output logic          seq_err,
    output logic          read_ready
);
    localparam int TMAX1 = (T_SETUP > T_ERASE) ? T_SETUP : T_ERASE;
    localparam int TMAX2 = (T_HOLD > T_RCV) ? T_HOLD : T_RCV;
    localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int CW    = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [CW-1:0] LD_SETUP = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] LD_ERASE = CW'(T_ERASE - 1);
    localparam logic [CW-1:0] LD_HOLD  = CW'(T_HOLD - 1);
    localparam logic [CW-1:0] LD_RCV   = CW'(T_RCV - 1);

    seq_state_t    st, st_n;
    logic          err_n;
    logic          ctrl_wr, req_erase, req_hv, clr_err, win_wr;
    logic          tmr_load, tmr_zero, fail;
    logic [CW-1:0] tmr_val;
    logic [1:0]    cur_bits, req_bits;

    erase_seq_decode #(
        .AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
        .ERASE_BIT(0), .HV_BIT(1), .CLR_BIT(7)
    ) u_decode (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_from_flash(wr_from_flash), .win_on_flash(win_on_flash),
        .ctrl_wr(ctrl_wr), .req_erase(req_erase), .req_hv(req_hv),
        .clr_err(clr_err), .win_wr(win_wr)
    );

    erase_seq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    // Request bits {erase, hv} that the current state stands for.
    always_comb begin
        case (st)
            S_ARMED, S_SETUP: cur_bits = 2'b10;
            S_ERASE:          cur_bits = 2'b11;
            S_HOLD:           cur_bits = 2'b01;
            default:          cur_bits = 2'b00;
        endcase
        req_bits = {req_erase, req_hv};
    end

    // Next-state, timer load and error decision for one cycle.
    always_comb begin
        st_n     = st;
        err_n    = seq_err;
        tmr_load = 1'b0;
        tmr_val  = '0;
        fail     = 1'b0;
        if (clr_err)
            err_n = 1'b0;
        if (st == S_RECOVER && tmr_zero)
            st_n = S_IDLE;
        if (win_wr) begin
            case (st)
                S_ARMED: begin
                    st_n     = S_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = LD_SETUP;
                end
                S_SETUP, S_ERASE, S_HOLD: fail = 1'b1;
                default: ;
            endcase
        end
        if (ctrl_wr && req_bits != cur_bits) begin
            case (st)
                S_IDLE: begin
                    if (req_bits != 2'b10)
                        fail = 1'b1;
                    else if (!seq_err)
                        st_n = S_ARMED;
                end
                S_SETUP: begin
                    if (req_bits == 2'b11 && tmr_zero) begin
                        st_n     = S_ERASE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_ERASE;
                    end else
                        fail = 1'b1;
                end
                S_ERASE: begin
                    if (req_bits == 2'b01 && tmr_zero) begin
                        st_n     = S_HOLD;
                        tmr_load = 1'b1;
                        tmr_val  = LD_HOLD;
                    end else
                        fail = 1'b1;
                end
                S_HOLD: begin
                    if (req_bits == 2'b00 && tmr_zero) begin
                        st_n     = S_RECOVER;
                        tmr_load = 1'b1;
                        tmr_val  = LD_RCV;
                    end else
                        fail = 1'b1;
                end
                default: fail = 1'b1;
            endcase
        end
        if (fail) begin
            st_n  = S_IDLE;
            err_n = 1'b1;
        end
    end

    // State and sticky error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            seq_err <= 1'b0;
        end else begin
            st      <= st_n;
            seq_err <= err_n;
        end
    end

    // Output decode from the state register.
    always_comb begin
        hv_en        = (st == S_ERASE) || (st == S_HOLD);
        erase_active = (st == S_ARMED) || (st == S_SETUP) || (st == S_ERASE);
        read_ready   = (st == S_IDLE);
    end

    // High voltage only turns on once the setup wait has run out.
    assert_hv_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> $past(tmr_zero));
    // A new error always leaves high voltage and erase off.
    assert_abort_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> (!hv_en && !erase_active));
    // The error holds until a clearing write.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !clr_err) |=> seq_err);
    // Writes from flash-fetched code change neither state nor error.
    assert_flash_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_from_flash && st != S_RECOVER) |=> (st == $past(st) && seq_err == $past(seq_err)));
endmodule

// File: tb/erase_sequencer_bench.sv
module erase_sequencer_bench;
    localparam int TS = 3;
    localparam int TE = 5;
    localparam int TH = 2;
    localparam int TR = 4;
    localparam logic [7:0] CTRL = 8'h10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       wr_from_flash;
    logic       win_on_flash;
    logic       hv_en, erase_active, seq_err, read_ready;
    int         nvec = 0;
    int         nerr = 0;
    bit         done = 1'b0;

    erase_sequencer #(
        .T_SETUP(TS), .T_ERASE(TE), .T_HOLD(TH), .T_RCV(TR)
    ) u_erase_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_from_flash(wr_from_flash), .win_on_flash(win_on_flash),
        .hv_en(hv_en), .erase_active(erase_active), .seq_err(seq_err), .read_ready(read_ready)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic fl, input logic win);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_from_flash = fl; win_on_flash = win;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_from_flash = 1'b0; win_on_flash = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Spend g-1 cycles after a step; fill them with traffic that must be harmless (R11).
    task automatic gap(input int g, input logic [7:0] bits);
        int left = g - 1;
        if (left >= 1) begin wr(CTRL, bits, 1'b0, 1'b1); left--; end
        if (left >= 1) begin wr(8'h20, 8'hFF, 1'b0, 1'b1); left--; end
        idle(left);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; idle(2); rst_n = 1'b1;
    endtask

    task automatic expect_abort(input string req);
        chk(req, "seq_err", int'(seq_err), 1);
        chk(req, "hv_en", int'(hv_en), 0);
        chk(req, "erase_active", int'(erase_active), 0);
        chk(req, "read_ready", int'(read_ready), 1);
    endtask

    // One erase run; step tgt (0 setup, 1 erase, 2 hold, 3 none) uses gap g.
    task automatic do_seq(input int tgt, input int g, input logic [7:0] waddr);
        wr(CTRL, 8'h80, 1'b0, 1'b1);
        chk("R10", "seq_err after clear", int'(seq_err), 0);
        wr(CTRL, 8'h01, 1'b0, 1'b1);
        chk("R2", "erase_active", int'(erase_active), 1);
        chk("R2", "read_ready", int'(read_ready), 0);
        wr(waddr, 8'h5A, 1'b0, 1'b1);
        chk("R3", "hv_en after window write", int'(hv_en), 0);
        gap((tgt == 0) ? g : TS, 8'h01);
        wr(CTRL, 8'h03, 1'b0, 1'b1);
        if (tgt == 0 && g < TS) begin expect_abort("R8"); return; end
        chk("R4", "hv_en", int'(hv_en), 1);
        chk("R4", "seq_err", int'(seq_err), 0);
        gap((tgt == 1) ? g : TE, 8'h03);
        wr(CTRL, 8'h02, 1'b0, 1'b1);
        if (tgt == 1 && g < TE) begin expect_abort("R8"); return; end
        chk("R5", "erase_active", int'(erase_active), 0);
        chk("R5", "hv_en", int'(hv_en), 1);
        gap((tgt == 2) ? g : TH, 8'h02);
        wr(CTRL, 8'h00, 1'b0, 1'b1);
        if (tgt == 2 && g < TH) begin expect_abort("R8"); return; end
        chk("R6", "hv_en", int'(hv_en), 0);
        chk("R6", "seq_err", int'(seq_err), 0);
        idle(TR - 1);
        chk("R7", "read_ready one cycle early", int'(read_ready), 0);
        idle(1);
        chk("R7", "read_ready on time", int'(read_ready), 1);
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        int tlim;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_from_flash = 1'b0; win_on_flash = 1'b1;
        rst_n = 1'b0;
        idle(1);
        do_reset();
        chk("R1", "hv_en", int'(hv_en), 0);
        chk("R1", "erase_active", int'(erase_active), 0);
        chk("R1", "seq_err", int'(seq_err), 0);
        chk("R1", "read_ready", int'(read_ready), 1);

        // Gap sweep over every timed step (R4, R5, R6, R8, R11).
        for (int tgt = 0; tgt < 3; tgt++) begin
            tlim = (tgt == 0) ? TS : (tgt == 1) ? TE : TH;
            for (int g = 1; g <= tlim + 1; g++)
                do_seq(tgt, g, 8'hC0 + 8'((g * 7) % 64));
        end
        do_seq(3, 0, 8'hFF);

        // R9: flash-fetched writes are dropped.
        wr(CTRL, 8'h01, 1'b1, 1'b1);
        chk("R9", "erase_active", int'(erase_active), 0);
        wr(CTRL, 8'h01, 1'b0, 1'b1);
        wr(8'hC4, 8'h00, 1'b0, 1'b1);
        idle(TS);
        wr(CTRL, 8'h03, 1'b1, 1'b1);
        chk("R9", "hv_en after flash write", int'(hv_en), 0);
        chk("R9", "seq_err after flash write", int'(seq_err), 0);
        wr(CTRL, 8'h03, 1'b0, 1'b1);
        chk("R4", "hv_en after RAM write", int'(hv_en), 1);
        // R8: window write during erase aborts.
        wr(8'hD0, 8'h00, 1'b0, 1'b1);
        expect_abort("R8");

        // R10: start request ignored while error set, then cleared by write.
        wr(CTRL, 8'h01, 1'b0, 1'b1);
        chk("R10", "erase_active while error", int'(erase_active), 0);
        chk("R10", "seq_err still set", int'(seq_err), 1);
        wr(CTRL, 8'h80, 1'b0, 1'b1);
        chk("R10", "seq_err cleared", int'(seq_err), 0);
        chk("R10", "erase_active after clear", int'(erase_active), 0);

        // R3: unmapped page does not arm; later high-voltage request is misordered.
        wr(CTRL, 8'h01, 1'b0, 1'b1);
        wr(8'hC0, 8'h00, 1'b0, 1'b0);
        idle(TS + 1);
        wr(CTRL, 8'h03, 1'b0, 1'b1);
        chk("R3", "unmapped write did not arm", int'(seq_err), 1);
        chk("R3", "hv_en", int'(hv_en), 0);
        wr(CTRL, 8'h80, 1'b0, 1'b1);

        // R3: address just below the window does not arm.
        wr(CTRL, 8'h01, 1'b0, 1'b1);
        wr(8'hBF, 8'h00, 1'b0, 1'b1);
        idle(TS + 1);
        wr(CTRL, 8'h03, 1'b0, 1'b1);
        chk("R3", "0xBF did not arm", int'(seq_err), 1);
        wr(CTRL, 8'h80, 1'b0, 1'b1);

        // R8: high-voltage request straight from idle.
        wr(CTRL, 8'h02, 1'b0, 1'b1);
        expect_abort("R8");

        // R10: reset also clears the error.
        do_reset();
        chk("R10", "seq_err after reset", int'(seq_err), 0);

        // R11: a repeated start request does not disturb arming.
        do_seq(3, 0, 8'hC0);

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
            $finish;
        end
    end
endmodule